// File: doc/BRIEF.md
# Partial-Word Merge Unit

This block carries out the four partial-word memory operations of a little-endian 32-bit core: load-left, load-right, store-left and store-right. The caller hands it an effective byte address, an operation code, a register number and the current register-file value for that register. The block accesses only the word-aligned address, that is, the effective address with its two low bits forced to zero. It then takes bytes from the fetched memory word and merges them into the register (for loads) or into the old memory contents (for stores). The two low address bits select which byte lanes move.

A load never writes the register file. Its merged word goes out as a one-cycle hand-off carrying the destination register number, for the core's delayed-load slot to take. The "old" register bytes that a load keeps come from that slot when the slot holds a pending load to the same register. Otherwise they come from the register file.

A store is a read-modify-write. The block reads the aligned word, merges the register bytes into it, and writes the result back to the same aligned address. A short sequencer runs the memory handshake. It accepts a request only when idle, and it ends each request with a one-cycle done pulse, with a fault flag set if the memory refused the read or the write.

Top module: `pw_merge_unit`

## Requirements
- R1: Every memory read and write is issued with `mem_addr` equal to `req_addr` with bits [1:0] cleared. Let b = `req_addr[1:0]`.
- R2: Load-left (`req_op`=0). For b=3 the result is the memory word. For b=2 it is mem<<8 with register byte 0 kept. For b=1 it is mem<<16 with register bytes 1..0 kept. For b=0 it is mem<<24 with register bytes 2..0 kept.
- R3: Load-right (`req_op`=1). For b=0 the result is the memory word. For b=1 it is mem>>8 with register byte 3 kept. For b=2 it is mem>>16 with register bytes 3..2 kept. For b=3 it is mem>>24 with register bytes 3..1 kept.
- R4: Store-left (`req_op`=2) writes the following. For b=3 the register. For b=2, reg>>8 with memory byte 3 kept. For b=1, reg>>16 with memory bytes 3..2 kept. For b=0, reg>>24 with memory bytes 3..1 kept.
- R5: Store-right (`req_op`=3) writes the following. For b=0 the register. For b=1, reg<<8 with memory byte 0 kept. For b=2, reg<<16 with memory bytes 1..0 kept. For b=3, reg<<24 with memory bytes 2..0 kept.
- R6: For loads, the kept register bytes come from `pend_value` when `pend_valid` is 1 and `pend_idx` equals `req_idx` at acceptance. In every other case they come from `reg_value`.
- R7: A successful load raises `load_valid` for exactly one cycle, together with `done`. It presents the merged word on `load_value` and `req_idx` on `load_idx`. A load issues no memory write.
- R8: A store issues one read, then one write of the merged word to the same aligned address. Read and write enables are never high together.
- R9: If the read response carries `mem_resp_fault`, the operation ends with `done` and `fault` high. No `load_valid` is raised and no write is issued.
- R10: If a store's write response carries `mem_resp_fault`, the operation ends with `done` and `fault` high.
- R11: `req_ready` is high only while idle. A `req_valid` seen while busy is ignored. Each accepted request produces exactly one one-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| req_addr | input | ADDR_W | Effective byte address |
| req_idx | input | IDX_W | Destination (load) or source (store) register number |
| reg_value | input | 32 | Register-file value of that register |
| pend_valid | input | 1 | Delayed-load slot holds a pending load |
| pend_idx | input | IDX_W | Register number of the pending load |
| pend_value | input | 32 | Value of the pending load |
| mem_rd_en | output | 1 | One-cycle read command |
| mem_wr_en | output | 1 | One-cycle write command |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Merged word for a store |
| mem_resp_valid | input | 1 | Memory response for the outstanding command |
| mem_resp_fault | input | 1 | Response reports a fault |
| mem_rdata | input | 32 | Read data, valid with the response |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was a fault, valid with done |
| load_valid | output | 1 | Load result hand-off to the delayed-load slot |
| load_idx | output | IDX_W | Destination register of the load result |
| load_value | output | 32 | Merged load word |

## Verification
A wrong byte-lane decode shows at the ports one cycle after the read response: on `load_value` for a load, or on `mem_wdata` in the write command for a store. Covering every offset for every operation exposes a lane slip at once. A wrong operand capture, such as forwarding on an index mismatch, shows only in the kept register bytes. So the forwarding cases use offsets that keep at least one register byte. A sequencer state error shows as a missing or doubled `done`, a write after a load, or a write after a faulted read. These appear within a few cycles of the memory response, and the bench counts command and pulse totals to catch them.

// File: rtl/pw_merge_pkg.sv
package pw_merge_pkg;

  localparam int WORD_W = 32;
  localparam int OFF_W  = 2;

  typedef enum logic [1:0] {
    OP_LD_LEFT  = 2'd0,
    OP_LD_RIGHT = 2'd1,
    OP_ST_LEFT  = 2'd2,
    OP_ST_RIGHT = 2'd3
  } merge_op_e;

  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  function automatic logic op_writes_mem(input merge_op_e op);
    return op[1];
  endfunction

  // high-side shift: 8*(3-off)
  function automatic logic [4:0] hi_shift(input logic [OFF_W-1:0] off);
    return {~off, 3'b000};
  endfunction

  // low-side shift: 8*off
  function automatic logic [4:0] lo_shift(input logic [OFF_W-1:0] off);
    return {off, 3'b000};
  endfunction

  function automatic logic [WORD_W-1:0] merge_load_left(
      input logic [WORD_W-1:0] regw, input logic [WORD_W-1:0] memw,
      input logic [OFF_W-1:0] off);
    logic [4:0] sh;
    sh = hi_shift(off);
    return (memw << sh) | (regw & ~(ALL_ONES << sh));
  endfunction

  function automatic logic [WORD_W-1:0] merge_load_right(
      input logic [WORD_W-1:0] regw, input logic [WORD_W-1:0] memw,
      input logic [OFF_W-1:0] off);
    logic [4:0] sh;
    sh = lo_shift(off);
    return (memw >> sh) | (regw & ~(ALL_ONES >> sh));
  endfunction

  function automatic logic [WORD_W-1:0] merge_store_left(
      input logic [WORD_W-1:0] regw, input logic [WORD_W-1:0] memw,
      input logic [OFF_W-1:0] off);
    logic [4:0] sh;
    sh = hi_shift(off);
    return (regw >> sh) | (memw & ~(ALL_ONES >> sh));
  endfunction

  function automatic logic [WORD_W-1:0] merge_store_right(
      input logic [WORD_W-1:0] regw, input logic [WORD_W-1:0] memw,
      input logic [OFF_W-1:0] off);
    logic [4:0] sh;
    sh = lo_shift(off);
    return (regw << sh) | (memw & ~(ALL_ONES << sh));
  endfunction

endpackage

// File: rtl/pw_operand_select.sv
module pw_operand_select
  import pw_merge_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              is_load,
  input  logic [IDX_W-1:0]  dest_idx,
  input  logic [WORD_W-1:0] rf_value,
  input  logic              slot_valid,
  input  logic [IDX_W-1:0]  slot_idx,
  input  logic [WORD_W-1:0] slot_value,
  output logic              fwd_hit,
  output logic [WORD_W-1:0] operand
);

  always_comb begin
    fwd_hit = is_load && slot_valid && (slot_idx == dest_idx);
    operand = fwd_hit ? slot_value : rf_value;
  end

endmodule

// File: rtl/pw_lane_merge.sv
module pw_lane_merge
  import pw_merge_pkg::*;
(
  input  merge_op_e         op,
  input  logic [OFF_W-1:0]  offset,
  input  logic [WORD_W-1:0] reg_word,
  input  logic [WORD_W-1:0] mem_word,
  output logic [WORD_W-1:0] merged
);

  always_comb begin
    unique case (op)
      OP_LD_LEFT:  merged = merge_load_left(reg_word, mem_word, offset);
      OP_LD_RIGHT: merged = merge_load_right(reg_word, mem_word, offset);
      OP_ST_LEFT:  merged = merge_store_left(reg_word, mem_word, offset);
      default:     merged = merge_store_right(reg_word, mem_word, offset);
    endcase
  end

endmodule

// File: rtl/pw_seq_fsm.sv
module pw_seq_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_store,
  input  logic resp_valid,
  input  logic resp_fault,
  output logic busy,
  output logic rd_issue,
  output logic wr_issue,
  output logic ev_rd_ok,
  output logic ev_rd_fault,
  output logic ev_wr_resp
);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ISSUE, S_RD_WAIT, S_WR_ISSUE, S_WR_WAIT
  } seq_state_e;

  seq_state_e state_q, state_d;

  always_comb begin
    busy        = (state_q != S_IDLE);
    rd_issue    = (state_q == S_RD_ISSUE);
    wr_issue    = (state_q == S_WR_ISSUE);
    ev_rd_ok    = (state_q == S_RD_WAIT) && resp_valid && !resp_fault;
    ev_rd_fault = (state_q == S_RD_WAIT) && resp_valid && resp_fault;
    ev_wr_resp  = (state_q == S_WR_WAIT) && resp_valid;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (start) state_d = S_RD_ISSUE;
      S_RD_ISSUE: state_d = S_RD_WAIT;
      S_RD_WAIT:  if (resp_valid)
                    state_d = (resp_fault || !is_store) ? S_IDLE : S_WR_ISSUE;
      S_WR_ISSUE: state_d = S_WR_WAIT;
      S_WR_WAIT:  if (resp_valid) state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pw_merge_unit.sv
module pw_merge_unit
  import pw_merge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [WORD_W-1:0] reg_value,
  input  logic              pend_valid,
  input  logic [IDX_W-1:0]  pend_idx,
  input  logic [WORD_W-1:0] pend_value,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_resp_valid,
  input  logic              mem_resp_fault,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic              load_valid,
  output logic [IDX_W-1:0]  load_idx,
  output logic [WORD_W-1:0] load_value
);

  localparam int WADDR_W = ADDR_W - OFF_W;

  merge_op_e          req_op_e;
  merge_op_e          op_q;
  logic [WADDR_W-1:0] waddr_q;
  logic [OFF_W-1:0]   off_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WORD_W-1:0]  operand_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [WORD_W-1:0]  operand_sel;
  logic [WORD_W-1:0]  merged;
  logic               fwd_hit;
  logic               busy;
  logic               accept;
  logic               op_is_store;
  logic               ev_rd_ok, ev_rd_fault, ev_wr_resp;
  logic               done_q, fault_q, load_valid_q;
  logic [WORD_W-1:0]  load_value_q;

  assign req_op_e    = merge_op_e'(req_op);
  assign accept      = req_valid && !busy;
  assign req_ready   = !busy;
  assign op_is_store = op_writes_mem(op_q);

  pw_operand_select #(.IDX_W(IDX_W)) u_opsel (
    .is_load    (!op_writes_mem(req_op_e)),
    .dest_idx   (req_idx),
    .rf_value   (reg_value),
    .slot_valid (pend_valid),
    .slot_idx   (pend_idx),
    .slot_value (pend_value),
    .fwd_hit    (fwd_hit),
    .operand    (operand_sel)
  );

  pw_lane_merge u_merge (
    .op       (op_q),
    .offset   (off_q),
    .reg_word (operand_q),
    .mem_word (mem_rdata),
    .merged   (merged)
  );

  pw_seq_fsm u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .is_store    (op_is_store),
    .resp_valid  (mem_resp_valid),
    .resp_fault  (mem_resp_fault),
    .busy        (busy),
    .rd_issue    (mem_rd_en),
    .wr_issue    (mem_wr_en),
    .ev_rd_ok    (ev_rd_ok),
    .ev_rd_fault (ev_rd_fault),
    .ev_wr_resp  (ev_wr_resp)
  );

  // request capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q      <= OP_LD_LEFT;
      waddr_q   <= '0;
      off_q     <= '0;
      idx_q     <= '0;
      operand_q <= '0;
    end else if (accept) begin
      op_q      <= req_op_e;
      waddr_q   <= req_addr[ADDR_W-1:OFF_W];
      off_q     <= req_addr[OFF_W-1:0];
      idx_q     <= req_idx;
      operand_q <= operand_sel;
    end
  end

  // merged store word held for the write command
  always_ff @(posedge clk) begin
    if (!rst_n)                       wdata_q <= '0;
    else if (ev_rd_ok && op_is_store) wdata_q <= merged;
  end

  // completion pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q       <= 1'b0;
      fault_q      <= 1'b0;
      load_valid_q <= 1'b0;
      load_value_q <= '0;
    end else begin
      done_q       <= ev_rd_fault || (ev_rd_ok && !op_is_store) || ev_wr_resp;
      fault_q      <= ev_rd_fault || (ev_wr_resp && mem_resp_fault);
      load_valid_q <= ev_rd_ok && !op_is_store;
      if (ev_rd_ok && !op_is_store) load_value_q <= merged;
    end
  end

  assign mem_addr   = {waddr_q, {OFF_W{1'b0}}};
  assign mem_wdata  = wdata_q;
  assign done       = done_q;
  assign fault      = fault_q;
  assign load_valid = load_valid_q;
  assign load_idx   = idx_q;
  assign load_value = load_value_q;

endmodule

// File: rtl/pw_merge_unit_chk.sv
module pw_merge_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              fault,
  input logic              load_valid,
  input logic              op_is_store
);

  logic [ADDR_W-1:0] last_rd_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         last_rd_addr_q <= '0;
    else if (mem_rd_en) last_rd_addr_q <= mem_addr;
  end

  assert_aligned_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> (mem_addr[1:0] == 2'b00));

  assert_load_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> (done && !fault));

  assert_no_load_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> op_is_store);

  assert_write_same_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_addr == last_rd_addr_q));

  assert_cmd_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_en, mem_wr_en}));

  assert_fault_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !load_valid);

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> !req_ready);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind pw_merge_unit pw_merge_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .mem_rd_en   (mem_rd_en),
  .mem_wr_en   (mem_wr_en),
  .mem_addr    (mem_addr),
  .done        (done),
  .fault       (fault),
  .load_valid  (load_valid),
  .op_is_store (op_is_store)
);

// File: tb/pw_merge_unit_tb_top.sv
`timescale 1ns/1ps
module pw_merge_unit_tb_top;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_idx = '0;
  logic [31:0] reg_value = '0;
  logic        pend_valid = 1'b0;
  logic [4:0]  pend_idx = '0;
  logic [31:0] pend_value = '0;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_resp_valid = 1'b0;
  logic        mem_resp_fault = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, fault, load_valid;
  logic [4:0]  load_idx;
  logic [31:0] load_value;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pw_merge_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_idx(req_idx), .reg_value(reg_value),
    .pend_valid(pend_valid), .pend_idx(pend_idx), .pend_value(pend_value),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_resp_valid(mem_resp_valid),
    .mem_resp_fault(mem_resp_fault), .mem_rdata(mem_rdata), .done(done),
    .fault(fault), .load_valid(load_valid), .load_idx(load_idx),
    .load_value(load_value)
  );

  // memory model and port monitor
  logic [31:0] mem_arr [0:15];
  logic        inj_rd_fault = 1'b0;
  logic        inj_wr_fault = 1'b0;
  int          cd = 0;
  logic        cmd_is_wr = 1'b0;
  int          rd_cnt = 0, wr_cnt = 0, ld_cnt = 0, done_cnt = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wdata = '0, ld_val = '0;
  logic [4:0]  ld_idx_s = '0;
  logic        last_fault = 1'b0;

  always @(negedge clk) begin
    mem_resp_valid = 1'b0;
    mem_resp_fault = 1'b0;
    if (cd > 0) begin
      cd = cd - 1;
      if (cd == 0) begin
        mem_resp_valid = 1'b1;
        mem_resp_fault = cmd_is_wr ? inj_wr_fault : inj_rd_fault;
        mem_rdata = (!cmd_is_wr && !inj_rd_fault) ? mem_arr[last_rd_addr[5:2]] : 32'hDEAD_BEEF;
      end
    end
    if (rst_n) begin
      if (mem_rd_en) begin
        rd_cnt++; last_rd_addr = mem_addr; cd = LAT; cmd_is_wr = 1'b0;
      end
      if (mem_wr_en) begin
        wr_cnt++; last_wr_addr = mem_addr; last_wdata = mem_wdata;
        cd = LAT; cmd_is_wr = 1'b1;
        if (!inj_wr_fault) mem_arr[mem_addr[5:2]] = mem_wdata;
      end
      if (load_valid) begin
        ld_cnt++; ld_val = load_value; ld_idx_s = load_idx;
      end
      if (done) begin
        done_cnt++; last_fault = fault;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference byte-lane models
  function automatic logic [31:0] ref_merge(input int op, input logic [31:0] r,
                                            input logic [31:0] m, input int b);
    logic [31:0] res;
    for (int i = 0; i < 4; i++) begin
      case (op)
        0: res[8*i +: 8] = (i >= 3-b) ? m[8*(i-(3-b)) +: 8] : r[8*i +: 8];
        1: res[8*i +: 8] = (i <= 3-b) ? m[8*(i+b) +: 8]     : r[8*i +: 8];
        2: res[8*i +: 8] = (i <= b)   ? r[8*(i+3-b) +: 8]   : m[8*i +: 8];
        default: res[8*i +: 8] = (i >= b) ? r[8*(i-b) +: 8] : m[8*i +: 8];
      endcase
    end
    return res;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input logic [4:0] idx,
                        input logic [31:0] rv, input logic pv, input logic [4:0] pidx,
                        input logic [31:0] pval);
    int start_done;
    int waited;
    start_done = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_idx = idx; reg_value = rv;
    pend_valid = pv; pend_idx = pidx; pend_value = pval;
    @(negedge clk);
    req_valid = 1'b0; pend_valid = 1'b0;
    reg_value = 32'h5A5A_5A5A; pend_value = 32'hA5A5_A5A5;
    waited = 0;
    while (done_cnt == start_done && waited < 100) begin
      @(negedge clk); waited++;
    end
    if (waited >= 100) check("R11 done timeout", 0, 1);
  endtask

  task automatic init_mem();
    for (int i = 0; i < 16; i++) mem_arr[i] = 32'h8172_6354 + i * 32'h0101_0101;
  endtask

  task automatic test_reset();
    check("R11 reset ready", {31'd0, req_ready}, 1);
    check("R11 reset done", {31'd0, done}, 0);
    check("R8 reset rd_en", {31'd0, mem_rd_en}, 0);
    check("R7 reset load_valid", {31'd0, load_valid}, 0);
  endtask

  task automatic test_loads(input int op, input string tag);
    for (int b = 0; b < 4; b++) begin
      int l0, w0;
      logic [31:0] addr, rv, m;
      addr = 32'h0000_0104 + 32'(b) + 32'(op) * 8;
      rv = 32'hC3B2_A190 ^ (32'(b) << 4);
      m = mem_arr[addr[5:2]];
      l0 = ld_cnt; w0 = wr_cnt;
      run_op(2'(op), addr, 5'd7 + 5'(b), rv, 1'b0, 5'd0, 0);
      check({tag, " merged value"}, ld_val, ref_merge(op, rv, m, b));
      check("R7 load idx", {27'd0, ld_idx_s}, {27'd0, 5'd7 + 5'(b)});
      check("R7 one load pulse", ld_cnt - l0, 1);
      check("R7 no write on load", wr_cnt - w0, 0);
      check("R1 read aligned", last_rd_addr, {addr[31:2], 2'b00});
    end
  endtask

  task automatic test_stores(input int op, input string tag);
    for (int b = 0; b < 4; b++) begin
      int w0, l0;
      logic [31:0] addr, rv, m, exp;
      addr = 32'h0000_0120 + 32'(b) + 32'(op) * 4;
      rv = 32'hF00D_1234 + 32'(b);
      m = mem_arr[addr[5:2]];
      exp = ref_merge(op, rv, m, b);
      w0 = wr_cnt; l0 = ld_cnt;
      run_op(2'(op), addr, 5'd3, rv, 1'b0, 5'd0, 0);
      check({tag, " written word"}, last_wdata, exp);
      check({tag, " memory after"}, mem_arr[addr[5:2]], exp);
      check("R8 one write", wr_cnt - w0, 1);
      check("R8 write same address", last_wr_addr, last_rd_addr);
      check("R1 write aligned", last_wr_addr, {addr[31:2], 2'b00});
      check("R7 no load pulse on store", ld_cnt - l0, 0);
      check("R11 store no fault", {31'd0, last_fault}, 0);
    end
  endtask

  task automatic test_forwarding();
    logic [31:0] m;
    m = mem_arr[1];
    // matching slot: kept byte from pend_value (load-left b=2 keeps byte 0)
    run_op(2'd0, 32'h0000_0106, 5'd9, 32'h1111_1111, 1'b1, 5'd9, 32'h2222_2222);
    check("R6 forward on match", ld_val, ref_merge(0, 32'h2222_2222, m, 2));
    run_op(2'd0, 32'h0000_0106, 5'd9, 32'h1111_1111, 1'b1, 5'd10, 32'h2222_2222);
    check("R6 no forward on idx mismatch", ld_val, ref_merge(0, 32'h1111_1111, m, 2));
    run_op(2'd1, 32'h0000_0105, 5'd9, 32'h3333_3333, 1'b0, 5'd9, 32'h4444_4444);
    check("R6 no forward when slot empty", ld_val, ref_merge(1, 32'h3333_3333, m, 1));
    // store never forwards
    run_op(2'd3, 32'h0000_0131, 5'd9, 32'h0000_00EE, 1'b1, 5'd9, 32'h0000_0077);
    check("R6 store uses register file", last_wdata[15:8], 8'hEE);
  endtask

  task automatic test_read_fault();
    int w0, l0;
    logic [31:0] m;
    m = mem_arr[4];
    w0 = wr_cnt; l0 = ld_cnt;
    inj_rd_fault = 1'b1;
    run_op(2'd2, 32'h0000_0111, 5'd4, 32'hFFFF_FFFF, 1'b0, 5'd0, 0);
    check("R9 fault flag store", {31'd0, last_fault}, 1);
    check("R9 no write after read fault", wr_cnt - w0, 0);
    check("R9 memory untouched", mem_arr[4], m);
    run_op(2'd1, 32'h0000_0112, 5'd4, 32'hFFFF_FFFF, 1'b0, 5'd0, 0);
    check("R9 fault flag load", {31'd0, last_fault}, 1);
    check("R9 no load pulse on fault", ld_cnt - l0, 0);
    inj_rd_fault = 1'b0;
  endtask

  task automatic test_write_fault();
    int l0;
    l0 = ld_cnt;
    inj_wr_fault = 1'b1;
    run_op(2'd3, 32'h0000_0116, 5'd4, 32'h1234_5678, 1'b0, 5'd0, 0);
    check("R10 write fault flag", {31'd0, last_fault}, 1);
    check("R10 no load pulse", ld_cnt - l0, 0);
    inj_wr_fault = 1'b0;
    run_op(2'd3, 32'h0000_0116, 5'd4, 32'h1234_5678, 1'b0, 5'd0, 0);
    check("R10 fault clears next op", {31'd0, last_fault}, 0);
  endtask

  task automatic test_busy_ignore();
    int r0, w0, d0, l0;
    logic [31:0] m;
    r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt; l0 = ld_cnt;
    m = mem_arr[2];
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 32'h0000_0108; req_idx = 5'd12;
    reg_value = 32'h0BAD_F00D;
    @(negedge clk);
    // while busy: present a store to another word
    req_op = 2'd3; req_addr = 32'h0000_010C; req_idx = 5'd13; reg_value = 32'hFFFF_FFFF;
    check("R11 not ready while busy", {31'd0, req_ready}, 0);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 12; k++) @(negedge clk);
    check("R11 one read only", rd_cnt - r0, 1);
    check("R11 no write from ignored store", wr_cnt - w0, 0);
    check("R11 single done", done_cnt - d0, 1);
    check("R11 result from accepted request", ld_val, ref_merge(0, 32'h0BAD_F00D, m, 0));
    check("R11 one load", ld_cnt - l0, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_loads(0, "R2 load-left");
    test_loads(1, "R3 load-right");
    test_stores(2, "R4 store-left");
    test_stores(3, "R5 store-right");
    test_forwarding();
    test_read_fault();
    test_write_fault();
    test_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule